// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block drives the control pins of a fractional-N PLL macro through a full reprogramming run each time it receives a start pulse. On that pulse it samples five values: the target VCO frequency, the input reference frequency, the integer and fractional feedback dividers, and the pre-divider. From the target and the divided reference it chooses the loop-filter gains. It then powers the macro up, holds it in reset, and writes the mode, VCO band, divider and gain outputs one step per clock. After that it releases reset and polls the lock indication at a fixed interval until lock is seen or the poll budget runs out.

Both frequencies are given in kHz. The divided reference is never formed with a divider. Each reference band edge is scaled by the pre-divider and compared against the raw input, which gives the same result as a floored division. When the targets are out of range, the sequencer raises an error pulse in the cycle after start and leaves every macro control output as it was. The done and error outputs are single-cycle pulses, and a second start that arrives during a run has no effect.

Top module: `pllseq_top`

## Requirements
- R1: The VCO target in kHz selects the integral gain and the proportional-gain row as follows: [700000, 2200000) gives Ki=4 and the mid row; [2200000, 3100000) gives Ki=3 and the high row; [3100000, 4000000) gives Ki=3 and the top row. Any other target raises error with errCode=1 one cycle after start, and no macro control output changes.
- R2: The divided reference is the input frequency divided by the pre-divider and floored. A pre-divider of 0 doubles the input frequency instead.
- R3: The reference bands, in kHz, are [10000,12500), [12500,15000), [15000,20000), [20000,25000), [25000,50000), [50000,75000), [75000,100000) and [100000,125000), numbered 0 to 7. The proportional gain is entry [band] of the selected row: mid {5,6,6,7,7,8,9,10}, high {4,4,5,5,6,7,8,9}, top {4,5,5,6,7,8,9,10}. A reference outside 10000 to 124999 kHz raises error with errCode=2. When both inputs are bad, the VCO error (code 1) takes priority.
- R4: The acceleration gain output is always written as 0.
- R5: In the lower VCO word, bit 30 is 1 exactly when the target is in [700000, 1200000) kHz, and bit 19 is 1 exactly when the target is at least 2200000 kHz. The upper VCO word is written as 0.
- R6: A run writes one item per clock, in this order: power up, assert reset, mode 7, upper word, lower word, integer divider, fractional divider (skipped when HAS_FRAC=0), pre-divider, gains, release reset. With lock already high, done pulses 11 clocks after the start edge (HAS_FRAC=1).
- R7: Both reset outputs carry the same value. They are at RST_LVL while any divider or gain output changes, and at the opposite level once the run has released reset.
- R8: Lock is sampled first in the clock after release and then every CLK_MHZ*POLL_US clocks, up to POLL_MAX samples. If no sample sees lock, error pulses with errCode=3.
- R9: done and error are single-cycle pulses and are never high together.
- R10: A start pulse that arrives while a run is in progress is ignored.
- R11: Out of reset, power is off, isolation is on, the mode is 0 and both reset outputs are at RST_LVL. Power-on with isolation off is driven before reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| vcoKhz | input | 32 | Target VCO frequency, kHz |
| refInKhz | input | 32 | Input reference frequency, kHz |
| ndivIntIn | input | NI_W | Integer feedback divider |
| ndivFracIn | input | NF_W | Fractional feedback divider |
| pdivIn | input | PD_W | Pre-divider (0 means x2) |
| lockIn | input | 1 | PLL lock indication |
| pllPwrOn | output | 1 | Macro power enable |
| pllIsoOn | output | 1 | Macro input isolation |
| pllRst | output | 1 | PLL reset |
| pllPostRst | output | 1 | Post-divider reset |
| macroMode | output | 3 | Macro mode field |
| vcoUpperWord | output | 32 | Upper VCO control word |
| vcoLowerWord | output | 32 | Lower VCO control word |
| ndivIntOut | output | NI_W | Integer divider to macro |
| ndivFracOut | output | NF_W | Fractional divider to macro |
| pdivOut | output | PD_W | Pre-divider to macro |
| kiOut | output | 3 | Integral gain |
| kpOut | output | 4 | Proportional gain |
| kaOut | output | 3 | Acceleration gain |
| done | output | 1 | Run finished with lock |
| error | output | 1 | Run aborted |
| errCode | output | 2 | Abort cause: 1 VCO, 2 reference, 3 lock |

## Verification
The assertions check four properties on every cycle. Divider and gain outputs change only while reset is held. The two reset outputs agree. A release of reset happens only with the macro powered, de-isolated and in mode 7. done and error stay exclusive pulses, and done appears only after release. The bench scenarios are the only place where gain selection, the band edges, error priority, the exact cycle of done, the poll interval, the timeout count and the dropping of a start during a run are shown.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  typedef struct packed {
    logic capture;
    logic pwrUp;
    logic rstOn;
    logic modeUser;
    logic vcoUpClr;
    logic vcoLoSet;
    logic nintWr;
    logic nfracWr;
    logic pdivWr;
    logic gainWr;
    logic rstOff;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_VCO  = 2'd1,
    ERR_REF  = 2'd2,
    ERR_LOCK = 2'd3
  } errCode_t;

  localparam int REF_EDGES = 9;
  localparam int unsigned REF_EDGE_KHZ [REF_EDGES] =
    '{10000, 12500, 15000, 20000, 25000, 50000, 75000, 100000, 125000};

  localparam int unsigned VCO_MIN_KHZ   = 700000;
  localparam int unsigned VCO_LOTOP_KHZ = 1200000;
  localparam int unsigned VCO_HI_KHZ    = 2200000;
  localparam int unsigned VCO_HH_KHZ    = 3100000;
  localparam int unsigned VCO_MAX_KHZ   = 4000000;

  localparam logic [2:0] MODE_USER = 3'd7;
  localparam int VCO_LO_BIT = 30;
  localparam int VCO_HI_BIT = 19;

  localparam logic [3:0] KP_TBL [3][8] = '{
    '{4'd5, 4'd6, 4'd6, 4'd7, 4'd7, 4'd8, 4'd9, 4'd10},
    '{4'd4, 4'd4, 4'd5, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9},
    '{4'd4, 4'd5, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10}
  };

endpackage

// File: rtl/pllseq_band.sv
module pllseq_band
  import pllseq_pkg::*;
#(
  parameter int PD_W = 4
) (
  input  logic [31:0]     vcoKhz,
  input  logic [31:0]     refInKhz,
  input  logic [PD_W-1:0] pdiv,
  output logic [3:0]      kp,
  output logic [2:0]      ki,
  output logic            vcoLoBit,
  output logic            vcoHiBit,
  output errCode_t        bandErr
);

  logic [63:0] scaledIn;
  logic [63:0] divFactor;
  logic [REF_EDGES-1:0] geEdge;
  logic [2:0] refBand;
  logic [1:0] kpRow;

  assign scaledIn  = (pdiv == '0) ? {31'b0, refInKhz, 1'b0} : {32'b0, refInKhz};
  assign divFactor = (pdiv == '0) ? 64'd1 : 64'(pdiv);

  // each band edge scaled by the pre-divider, compared against the raw input
  for (genvar j = 0; j < REF_EDGES; j++) begin : gEdge
    assign geEdge[j] = scaledIn >= (64'(REF_EDGE_KHZ[j]) * divFactor);
  end

  always_comb begin
    refBand = '0;
    for (int j = 1; j < REF_EDGES - 1; j++) refBand = refBand + 3'(geEdge[j]);
  end

  always_comb begin
    bandErr = ERR_NONE;
    kpRow   = 2'd0;
    ki      = 3'd4;
    if (vcoKhz >= VCO_MIN_KHZ && vcoKhz < VCO_HI_KHZ) begin
      kpRow = 2'd0; ki = 3'd4;
    end else if (vcoKhz >= VCO_HI_KHZ && vcoKhz < VCO_HH_KHZ) begin
      kpRow = 2'd1; ki = 3'd3;
    end else if (vcoKhz >= VCO_HH_KHZ && vcoKhz < VCO_MAX_KHZ) begin
      kpRow = 2'd2; ki = 3'd3;
    end else begin
      bandErr = ERR_VCO;
    end
    if (bandErr == ERR_NONE && (!geEdge[0] || geEdge[REF_EDGES-1])) bandErr = ERR_REF;
  end

  assign kp       = KP_TBL[kpRow][refBand];
  assign vcoLoBit = (vcoKhz >= VCO_MIN_KHZ) && (vcoKhz < VCO_LOTOP_KHZ);
  assign vcoHiBit = vcoKhz >= VCO_HI_KHZ;

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter bit HAS_FRAC = 1'b1,
  parameter int INTERVAL = 2500,
  parameter int POLL_MAX = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lockIn,
  input  errCode_t   bandErr,
  output seqStrobe_t stb,
  output logic       done,
  output logic       error,
  output errCode_t   errCode
);

  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int SW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_RST, S_MODE, S_VUP, S_VLO,
    S_NINT, S_NFRAC, S_PDIV, S_GAIN, S_REL, S_POLL
  } state_t;

  state_t state, nxt;
  logic [TW-1:0] tick;
  logic [SW-1:0] samp;
  logic sampleNow, lastSample;

  assign sampleNow  = (state == S_POLL) && (tick == '0);
  assign lastSample = samp == SW'(POLL_MAX - 1);

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      S_IDLE:  if (start && bandErr == ERR_NONE) begin stb.capture = 1'b1; nxt = S_PWR; end
      S_PWR:   begin stb.pwrUp    = 1'b1; nxt = S_RST;  end
      S_RST:   begin stb.rstOn    = 1'b1; nxt = S_MODE; end
      S_MODE:  begin stb.modeUser = 1'b1; nxt = S_VUP;  end
      S_VUP:   begin stb.vcoUpClr = 1'b1; nxt = S_VLO;  end
      S_VLO:   begin stb.vcoLoSet = 1'b1; nxt = S_NINT; end
      S_NINT:  begin stb.nintWr   = 1'b1; nxt = HAS_FRAC ? S_NFRAC : S_PDIV; end
      S_NFRAC: begin stb.nfracWr  = 1'b1; nxt = S_PDIV; end
      S_PDIV:  begin stb.pdivWr   = 1'b1; nxt = S_GAIN; end
      S_GAIN:  begin stb.gainWr   = 1'b1; nxt = S_REL;  end
      S_REL:   begin stb.rstOff   = 1'b1; nxt = S_POLL; end
      S_POLL:  if (sampleNow && (lockIn || lastSample)) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tick    <= '0;
      samp    <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      state <= nxt;
      done  <= 1'b0;
      error <= 1'b0;
      if (state == S_IDLE && start && bandErr != ERR_NONE) begin
        error   <= 1'b1;
        errCode <= bandErr;
      end
      if (state == S_REL) begin
        tick <= '0;
        samp <= '0;
      end else if (state == S_POLL) begin
        if (sampleNow) begin
          if (lockIn) begin
            done    <= 1'b1;
            errCode <= ERR_NONE;
          end else if (lastSample) begin
            error   <= 1'b1;
            errCode <= ERR_LOCK;
          end else begin
            samp <= samp + 1'b1;
            tick <= TW'(INTERVAL - 1);
          end
        end else begin
          tick <= tick - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pllseq_dp.sv
module pllseq_dp
  import pllseq_pkg::*;
#(
  parameter int   NI_W   = 10,
  parameter int   NF_W   = 20,
  parameter int   PD_W   = 4,
  parameter logic RST_LVL = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      stb,
  input  logic [3:0]      kpIn,
  input  logic [2:0]      kiIn,
  input  logic            vcoLoIn,
  input  logic            vcoHiIn,
  input  logic [NI_W-1:0] ndivIntIn,
  input  logic [NF_W-1:0] ndivFracIn,
  input  logic [PD_W-1:0] pdivIn,
  output logic            pllPwrOn,
  output logic            pllIsoOn,
  output logic            pllRst,
  output logic            pllPostRst,
  output logic [2:0]      macroMode,
  output logic [31:0]     vcoUpperWord,
  output logic [31:0]     vcoLowerWord,
  output logic [NI_W-1:0] ndivIntOut,
  output logic [NF_W-1:0] ndivFracOut,
  output logic [PD_W-1:0] pdivOut,
  output logic [2:0]      kiOut,
  output logic [3:0]      kpOut,
  output logic [2:0]      kaOut
);

  logic [3:0]      shKp;
  logic [2:0]      shKi;
  logic            shLo, shHi;
  logic [NI_W-1:0] shInt;
  logic [NF_W-1:0] shFrac;
  logic [PD_W-1:0] shPdiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shKp <= '0; shKi <= '0; shLo <= 1'b0; shHi <= 1'b0;
      shInt <= '0; shFrac <= '0; shPdiv <= '0;
      pllPwrOn <= 1'b0;
      pllIsoOn <= 1'b1;
      pllRst <= RST_LVL;
      pllPostRst <= RST_LVL;
      macroMode <= '0;
      vcoUpperWord <= '0;
      vcoLowerWord <= '0;
      ndivIntOut <= '0;
      ndivFracOut <= '0;
      pdivOut <= '0;
      kiOut <= '0;
      kpOut <= '0;
      kaOut <= '0;
    end else begin
      if (stb.capture) begin
        shKp <= kpIn; shKi <= kiIn; shLo <= vcoLoIn; shHi <= vcoHiIn;
        shInt <= ndivIntIn; shFrac <= ndivFracIn; shPdiv <= pdivIn;
      end
      if (stb.pwrUp) begin
        pllPwrOn <= 1'b1;
        pllIsoOn <= 1'b0;
      end
      if (stb.rstOn) begin
        pllRst <= RST_LVL;
        pllPostRst <= RST_LVL;
      end
      if (stb.modeUser) macroMode <= MODE_USER;
      if (stb.vcoUpClr) vcoUpperWord <= '0;
      if (stb.vcoLoSet) begin
        vcoLowerWord[VCO_LO_BIT] <= shLo;
        vcoLowerWord[VCO_HI_BIT] <= shHi;
      end
      if (stb.nintWr)  ndivIntOut <= shInt;
      if (stb.nfracWr) ndivFracOut <= shFrac;
      if (stb.pdivWr)  pdivOut <= shPdiv;
      if (stb.gainWr) begin
        kiOut <= shKi;
        kpOut <= shKp;
        kaOut <= 3'd0;
      end
      if (stb.rstOff) begin
        pllRst <= ~RST_LVL;
        pllPostRst <= ~RST_LVL;
      end
    end
  end

endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
  import pllseq_pkg::*;
#(
  parameter int   CLK_MHZ  = 250,
  parameter int   POLL_US  = 10,
  parameter int   POLL_MAX = 100,
  parameter bit   HAS_FRAC = 1'b1,
  parameter logic RST_LVL  = 1'b0,
  parameter int   NI_W     = 10,
  parameter int   NF_W     = 20,
  parameter int   PD_W     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [31:0]     vcoKhz,
  input  logic [31:0]     refInKhz,
  input  logic [NI_W-1:0] ndivIntIn,
  input  logic [NF_W-1:0] ndivFracIn,
  input  logic [PD_W-1:0] pdivIn,
  input  logic            lockIn,
  output logic            pllPwrOn,
  output logic            pllIsoOn,
  output logic            pllRst,
  output logic            pllPostRst,
  output logic [2:0]      macroMode,
  output logic [31:0]     vcoUpperWord,
  output logic [31:0]     vcoLowerWord,
  output logic [NI_W-1:0] ndivIntOut,
  output logic [NF_W-1:0] ndivFracOut,
  output logic [PD_W-1:0] pdivOut,
  output logic [2:0]      kiOut,
  output logic [3:0]      kpOut,
  output logic [2:0]      kaOut,
  output logic            done,
  output logic            error,
  output logic [1:0]      errCode
);

  localparam int INTERVAL = CLK_MHZ * POLL_US;

  seqStrobe_t stb;
  errCode_t   bandErr, errCodeE;
  logic [3:0] kpSel;
  logic [2:0] kiSel;
  logic       loSel, hiSel;

  pllseq_band #(.PD_W(PD_W)) uBand (
    .vcoKhz(vcoKhz), .refInKhz(refInKhz), .pdiv(pdivIn),
    .kp(kpSel), .ki(kiSel), .vcoLoBit(loSel), .vcoHiBit(hiSel), .bandErr(bandErr)
  );

  pllseq_ctrl #(.HAS_FRAC(HAS_FRAC), .INTERVAL(INTERVAL), .POLL_MAX(POLL_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lockIn(lockIn), .bandErr(bandErr),
    .stb(stb), .done(done), .error(error), .errCode(errCodeE)
  );

  assign errCode = errCodeE;

  pllseq_dp #(.NI_W(NI_W), .NF_W(NF_W), .PD_W(PD_W), .RST_LVL(RST_LVL)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .kpIn(kpSel), .kiIn(kiSel), .vcoLoIn(loSel), .vcoHiIn(hiSel),
    .ndivIntIn(ndivIntIn), .ndivFracIn(ndivFracIn), .pdivIn(pdivIn),
    .pllPwrOn(pllPwrOn), .pllIsoOn(pllIsoOn), .pllRst(pllRst), .pllPostRst(pllPostRst),
    .macroMode(macroMode), .vcoUpperWord(vcoUpperWord), .vcoLowerWord(vcoLowerWord),
    .ndivIntOut(ndivIntOut), .ndivFracOut(ndivFracOut), .pdivOut(pdivOut),
    .kiOut(kiOut), .kpOut(kpOut), .kaOut(kaOut)
  );

endmodule

// File: rtl/pllseq_checker.sv
module pllseq_checker #(
  parameter logic RST_LVL = 1'b0,
  parameter int   NI_W    = 10,
  parameter int   PD_W    = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            done,
  input logic            error,
  input logic            pllRst,
  input logic            pllPostRst,
  input logic            pllPwrOn,
  input logic            pllIsoOn,
  input logic [2:0]      macroMode,
  input logic [3:0]      kpOut,
  input logic [2:0]      kiOut,
  input logic [NI_W-1:0] ndivIntOut,
  input logic [PD_W-1:0] pdivOut
);

  AST_PROG_UNDER_RST: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(kpOut) || !$stable(kiOut) || !$stable(ndivIntOut) || !$stable(pdivOut))
      |-> (pllRst == RST_LVL)); // R7

  AST_RST_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    pllRst == pllPostRst); // R7

  AST_RELEASE_READY: assert property (@(posedge clk) disable iff (!rstN)
    (pllRst != RST_LVL && $past(pllRst) == RST_LVL)
      |-> (macroMode == 3'd7 && pllPwrOn && !pllIsoOn)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R9

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pllRst != RST_LVL)); // R8

endmodule

bind pllseq_top pllseq_checker #(.RST_LVL(RST_LVL), .NI_W(NI_W), .PD_W(PD_W)) uChk (
  .clk(clk), .rstN(rstN), .done(done), .error(error),
  .pllRst(pllRst), .pllPostRst(pllPostRst), .pllPwrOn(pllPwrOn), .pllIsoOn(pllIsoOn),
  .macroMode(macroMode), .kpOut(kpOut), .kiOut(kiOut),
  .ndivIntOut(ndivIntOut), .pdivOut(pdivOut)
);

// File: tb/pllseq_top_test.sv
`timescale 1ns/1ps
module pllseq_top_test;

  localparam int NI_W = 10, NF_W = 20, PD_W = 4;
  localparam int INTERVAL = 10;   // CLK_MHZ=1, POLL_US=10
  localparam int NVEC = 16;

  // fields: vco[78:47] in[46:15] pdiv[14:11] kp[10:7] ki[6:4] b30[3] b19[2] code[1:0]
  localparam logic [78:0] VEC [NVEC] = '{
    {32'd1000000, 32'd25000,  4'd1, 4'd7,  3'd4, 1'b1, 1'b0, 2'd0},
    {32'd2500000, 32'd50000,  4'd0, 4'd9,  3'd3, 1'b0, 1'b1, 2'd0},
    {32'd3500000, 32'd100000, 4'd8, 4'd5,  3'd3, 1'b0, 1'b1, 2'd0},
    {32'd1500000, 32'd30000,  4'd3, 4'd5,  3'd4, 1'b0, 1'b0, 2'd0},
    {32'd2199999, 32'd124999, 4'd1, 4'd10, 3'd4, 1'b0, 1'b0, 2'd0},
    {32'd2200000, 32'd20000,  4'd1, 4'd5,  3'd3, 1'b0, 1'b1, 2'd0},
    {32'd3100000, 32'd15000,  4'd1, 4'd5,  3'd3, 1'b0, 1'b1, 2'd0},
    {32'd1199999, 32'd60000,  4'd2, 4'd7,  3'd4, 1'b1, 1'b0, 2'd0},
    {32'd1200000, 32'd40000,  4'd0, 4'd9,  3'd4, 1'b0, 1'b0, 2'd0},
    {32'd699999,  32'd25000,  4'd1, 4'd0,  3'd0, 1'b0, 1'b0, 2'd1},
    {32'd4000000, 32'd25000,  4'd1, 4'd0,  3'd0, 1'b0, 1'b0, 2'd1},
    {32'd1000000, 32'd125000, 4'd1, 4'd0,  3'd0, 1'b0, 1'b0, 2'd2},
    {32'd1000000, 32'd29999,  4'd3, 4'd0,  3'd0, 1'b0, 1'b0, 2'd2},
    {32'd5000000, 32'd1000,   4'd1, 4'd0,  3'd0, 1'b0, 1'b0, 2'd1},
    {32'd3999999, 32'd62500,  4'd0, 4'd0,  3'd0, 1'b0, 1'b0, 2'd2},
    {32'd3999999, 32'd12499,  4'd1, 4'd4,  3'd3, 1'b0, 1'b1, 2'd0}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, lockIn = 1'b0;
  logic [31:0] vcoKhz = '0, refInKhz = '0;
  logic [NI_W-1:0] ndivIntIn = '0;
  logic [NF_W-1:0] ndivFracIn = '0;
  logic [PD_W-1:0] pdivIn = '0;
  logic pllPwrOn, pllIsoOn, pllRst, pllPostRst, done, error;
  logic [2:0] macroMode, kiOut, kaOut;
  logic [31:0] vcoUpperWord, vcoLowerWord;
  logic [NI_W-1:0] ndivIntOut;
  logic [NF_W-1:0] ndivFracOut;
  logic [PD_W-1:0] pdivOut;
  logic [3:0] kpOut;
  logic [1:0] errCode;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pllseq_top #(.CLK_MHZ(1), .POLL_US(10), .POLL_MAX(100)) uut (
    .clk(clk), .rstN(rstN), .start(start), .vcoKhz(vcoKhz), .refInKhz(refInKhz),
    .ndivIntIn(ndivIntIn), .ndivFracIn(ndivFracIn), .pdivIn(pdivIn), .lockIn(lockIn),
    .pllPwrOn(pllPwrOn), .pllIsoOn(pllIsoOn), .pllRst(pllRst), .pllPostRst(pllPostRst),
    .macroMode(macroMode), .vcoUpperWord(vcoUpperWord), .vcoLowerWord(vcoLowerWord),
    .ndivIntOut(ndivIntOut), .ndivFracOut(ndivFracOut), .pdivOut(pdivOut),
    .kiOut(kiOut), .kpOut(kpOut), .kaOut(kaOut),
    .done(done), .error(error), .errCode(errCode)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  // drives a start; n = clocks after the start edge at which done/error is seen
  task automatic runSeq(input logic [31:0] vco, input logic [31:0] rin, input logic [PD_W-1:0] pd,
                        input logic [NI_W-1:0] ni, input logic [NF_W-1:0] nf,
                        output int n, output bit gotDone, output bit gotErr);
    vcoKhz = vco; refInKhz = rin; pdivIn = pd; ndivIntIn = ni; ndivFracIn = nf;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    n = 0;
    while (!done && !error && n < 3000) begin
      @(posedge clk); #1;
      n++;
    end
    gotDone = done;
    gotErr = error;
  endtask

  task automatic idle(input int c);
    for (int k = 0; k < c; k++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    bit gd, ge;
    logic [3:0] lastKp;
    logic [2:0] lastKi;

    idle(3);
    // R11: reset state
    chkEq("R11 pwr", pllPwrOn, 0);
    chkEq("R11 iso", pllIsoOn, 1);
    chkEq("R11 rst", pllRst, 0);
    chkEq("R11 mode", macroMode, 0);
    chk(!done && !error, "R9 idle pulses", {done, error}, 0);
    rstN = 1'b1;
    lockIn = 1'b1;
    idle(2);
    lastKp = '0; lastKi = '0;

    for (int i = 0; i < NVEC; i++) begin
      logic [78:0] v;
      v = VEC[i];
      runSeq(v[78:47], v[46:15], v[14:11], NI_W'(100 + i), NF_W'(i * 777), n, gd, ge);
      if (v[1:0] == 2'd0) begin
        chk(gd && n == 11, "R6 done cycle", n, 11);
        chkEq("R1 ki", kiOut, v[6:4]);
        chkEq("R2/R3 kp", kpOut, v[10:7]);
        chkEq("R4 ka", kaOut, 0);
        chkEq("R5 bit30", vcoLowerWord[30], v[3]);
        chkEq("R5 bit19", vcoLowerWord[19], v[2]);
        chkEq("R5 upper", vcoUpperWord, 0);
        chkEq("R6 ndivInt", ndivIntOut, 100 + i);
        chkEq("R6 ndivFrac", ndivFracOut, NF_W'(i * 777));
        chkEq("R6 pdiv", pdivOut, v[14:11]);
        chkEq("R7 released", pllRst, 1);
        chkEq("R6 mode", macroMode, 7);
        lastKp = kpOut; lastKi = kiOut;
        if (i == 0) begin
          idle(1);
          chkEq("R9 done width", done, 0);
        end
      end else begin
        chk(ge && n == 0, "R1/R3 error cycle", n, 0);
        chkEq("R1/R3 code", errCode, v[1:0]);
        chkEq("R1 kp untouched", kpOut, lastKp);
        chkEq("R1 ki untouched", kiOut, lastKi);
        idle(1);
        chkEq("R9 error width", error, 0);
      end
      idle(2);
    end

    // R10 and R11: second start mid-run is dropped; power precedes reset assert
    vcoKhz = 1000000; refInKhz = 25000; pdivIn = 1; ndivIntIn = 10'd55; ndivFracIn = '0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    n = 0;
    while (!done && !error && n < 3000) begin
      @(posedge clk); #1;
      n++;
      if (n == 1) begin
        chkEq("R11 pwr before rst", pllPwrOn, 1);
        chkEq("R11 rst not yet", pllRst, 1);
      end
      if (n == 2) chkEq("R7 rst asserted", pllRst, 0);
      if (n == 3) begin
        vcoKhz = 2500000; refInKhz = 50000; pdivIn = 0; ndivIntIn = 10'd99;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n++;
      end
    end
    chk(done && n == 11, "R10 done cycle", n, 11);
    chkEq("R10 kp first", kpOut, 7);
    chkEq("R10 ndiv first", ndivIntOut, 55);
    gd = 0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1;
      if (done || error) gd = 1;
    end
    chkEq("R10 no second run", gd, 0);

    // R8: lock arrives late, seen at second sample
    lockIn = 1'b0;
    fork
      runSeq(32'd1000000, 32'd25000, 4'd1, 10'd7, 20'd0, n, gd, ge);
      begin idle(15); lockIn = 1'b1; end
    join
    chk(gd && n == 11 + INTERVAL, "R8 late lock", n, 11 + INTERVAL);
    idle(2);

    // R8: timeout
    lockIn = 1'b0;
    runSeq(32'd1000000, 32'd25000, 4'd1, 10'd7, 20'd0, n, gd, ge);
    chk(ge && n == 11 + 99 * INTERVAL, "R8 timeout cycle", n, 11 + 99 * INTERVAL);
    chkEq("R8 timeout code", errCode, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule